// File: doc/BRIEF.md
# Hash input word formatter

This block sits on the data write port of a digest accelerator. A processor or a DMA engine writes 32-bit message words to a single write-only port. Each word is reordered according to a programmed byte order and then sent out one byte at a time, under a valid/ready handshake, toward the hash core. The bytes are counted against the programmed message length.

The write port carries no per-byte valid mask. The final word of a message may therefore hold fewer than four useful bytes, and the block trims it using only the programmed length. A word that arrives before any configuration, or after the message length is used up, is consumed and dropped, and a one-cycle error pulse is raised. After each configuration write the port stays closed for two cycles, so that the first data word is never merged with the configuration. DMA engines that write bursts of up to four words are served by the ordinary per-word handshake.

Top module: `hash_word_formatter`

## Requirements
- R1: After reset the block is unconfigured: wr_ready is 1, out_valid is 0 and wr_err is 0.
- R2: A cycle with cfg_we high loads the byte order and sets the remaining byte count to cfg_len_bits divided by 8, with bits [2:0] discarded. Any bytes still pending from an earlier word are abandoned.
- R3: For the two cycles after a cfg_we cycle, wr_ready is 0. Write data offered then is stalled, not lost.
- R4: The first byte emitted for an accepted word depends on cfg_order, where lane k is wr_data[8k+7:8k]. The emission order is: code 0, lanes 3,2,1,0; code 1, lanes 0,1,2,3; code 2, lanes 2,3,1,0; code 3, lanes 1,0,3,2.
- R5: An accepted word emits min(4, remaining) bytes, and the lanes beyond that are discarded. out_last is 1 exactly on the byte that brings the remaining count to zero.
- R6: wr_ready is 0 while any byte of the previous word is still pending. It returns to 1 in the cycle after the last byte handshake.
- R7: A word accepted while unconfigured emits no bytes, and wr_err is 1 for exactly the following cycle.
- R8: A word accepted when the remaining count is zero (including a zero length) emits no bytes, and wr_err is 1 for exactly the following cycle.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_order | input | 2 | Byte order code |
| cfg_len_bits | input | LEN_W | Message length in bits |
| wr_valid | input | 1 | Data word offered |
| wr_data | input | 32 | Data word |
| wr_ready | output | 1 | Data word can be taken this cycle |
| wr_err | output | 1 | One-cycle pulse for a rejected word |
| out_valid | output | 1 | Byte available to the core |
| out_byte | output | 8 | Message byte |
| out_last | output | 1 | Final byte of the message |
| out_ready | input | 1 | Core takes the byte |

## Verification
Each result has a fixed arrival cycle:
- The first byte of an accepted word appears in the cycle after the write handshake.
- Each later byte appears in the cycle after the previous byte's handshake.
- wr_err appears in the cycle after the rejected handshake.
- wr_ready returns one cycle after the final byte is taken, or three cycles after a configuration write.

The bench model advances its state on the same rising edge as the design, using the inputs it drove half a cycle earlier. It compares every output at the falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/hash_word_formatter.sv
module hash_word_formatter #(
  parameter int LEN_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_order,
  input  logic [LEN_W-1:0] cfg_len_bits,
  input  logic             wr_valid,
  input  logic [31:0]      wr_data,
  output logic             wr_ready,
  output logic             wr_err,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             out_last,
  input  logic             out_ready
);
  localparam int CNT_W = LEN_W - 3;

  logic             cfgd;
  logic [1:0]       order_q;
  logic [1:0]       guard;
  logic [CNT_W-1:0] rem;
  logic [2:0]       pend;
  logic [31:0]      sh;
  logic [31:0]      perm;
  logic [2:0]       nb;

  always_comb begin
    case (order_q)
      2'd0:    perm = wr_data;
      2'd1:    perm = {wr_data[7:0], wr_data[15:8], wr_data[23:16], wr_data[31:24]};
      2'd2:    perm = {wr_data[23:16], wr_data[31:24], wr_data[15:8], wr_data[7:0]};
      default: perm = {wr_data[15:8], wr_data[7:0], wr_data[31:24], wr_data[23:16]};
    endcase
  end

  assign nb        = (rem > CNT_W'(3)) ? 3'd4 : rem[2:0];
  assign wr_ready  = (guard == 2'd0) && (pend == 3'd0);
  assign out_valid = (pend != 3'd0);
  assign out_byte  = sh[31:24];
  assign out_last  = out_valid && (rem == CNT_W'(1));

  wire acc  = wr_valid && wr_ready;
  wire take = acc && cfgd && (rem != '0);
  wire pop  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgd    <= 1'b0;
      order_q <= 2'd0;
      guard   <= 2'd0;
      rem     <= '0;
      pend    <= 3'd0;
      sh      <= '0;
      wr_err  <= 1'b0;
    end else begin
      wr_err <= acc && (!cfgd || rem == '0);
      if (cfg_we) begin
        cfgd    <= 1'b1;
        order_q <= cfg_order;
        rem     <= cfg_len_bits[LEN_W-1:3];
        guard   <= 2'd2;
        pend    <= 3'd0;
      end else begin
        if (guard != 2'd0) guard <= guard - 2'd1;
        if (pop) begin
          sh   <= sh << 8;
          pend <= pend - 3'd1;
          rem  <= rem - CNT_W'(1);
        end
        if (take) begin
          sh   <= perm;
          pend <= nb;
        end
      end
    end
  end

  a_r3_guard: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !wr_ready ##1 !wr_ready);
  a_r6_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cfg_we) |=> (out_valid && !wr_ready));
  a_r7_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cfgd) |=> (wr_err && !out_valid));
  a_r8_exhausted: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cfgd && rem == '0) |=> (wr_err && !out_valid));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !cfg_we) |=> (out_valid && $stable(out_byte)));
  a_r5_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && out_last && !cfg_we) |=> !out_valid);
endmodule

// File: tb/hash_word_formatter_bench.sv
module hash_word_formatter_bench;
  localparam int LEN_W = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_order = 2'd0;
  logic [LEN_W-1:0] cfg_len_bits = '0;
  logic             wr_valid = 1'b0;
  logic [31:0]      wr_data = '0;
  logic             wr_ready, wr_err, out_valid, out_last;
  logic [7:0]       out_byte;
  logic             out_ready = 1'b1;

  hash_word_formatter #(.LEN_W(LEN_W)) u_hash_word_formatter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_order(cfg_order),
    .cfg_len_bits(cfg_len_bits), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_err(wr_err), .out_valid(out_valid),
    .out_byte(out_byte), .out_last(out_last), .out_ready(out_ready));

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp_en = 1'b0;
  bit done = 1'b0;

  bit        m_cfgd;
  int        m_guard;
  longint    m_rem;
  int        m_order;
  bit        m_err;
  logic [7:0] m_q[$];

  function automatic int lane_of(int code, int k);
    int t0[4] = '{3, 2, 1, 0};
    int t1[4] = '{0, 1, 2, 3};
    int t2[4] = '{2, 3, 1, 0};
    int t3[4] = '{1, 0, 3, 2};
    case (code)
      0: return t0[k];
      1: return t1[k];
      2: return t2[k];
      default: return t3[k];
    endcase
  endfunction

  function automatic bit m_ready();
    return (m_guard == 0) && (m_q.size() == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfgd = 0; m_guard = 0; m_rem = 0; m_order = 0; m_err = 0;
      m_q.delete();
    end else begin
      bit acc;
      acc = wr_valid && m_ready();
      m_err = acc && (!m_cfgd || m_rem == 0);
      if (cfg_we) begin
        m_cfgd = 1; m_order = cfg_order; m_rem = longint'(cfg_len_bits >> 3);
        m_guard = 2; m_q.delete();
      end else begin
        if (m_guard > 0) m_guard--;
        if (m_q.size() > 0 && out_ready) begin
          void'(m_q.pop_front());
          m_rem--;
        end else if (acc && m_cfgd && m_rem > 0) begin
          for (int k = 0; k < ((m_rem > 4) ? 4 : int'(m_rem)); k++)
            m_q.push_back(wr_data[8*lane_of(m_order, k) +: 8]);
        end
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    out_ready <= !bp_en || (cyc % 3 != 0);
    if (rst_n) begin
      chk(wr_ready === m_ready(), "R3 R6 wr_ready", 32'(wr_ready), 32'(m_ready()));
      chk(out_valid === (m_q.size() > 0), "R5 R9 out_valid", 32'(out_valid), 32'(m_q.size() > 0));
      chk(wr_err === m_err, "R7 R8 wr_err", 32'(wr_err), 32'(m_err));
      if (m_q.size() > 0) begin
        chk(out_byte === m_q[0], "R4 out_byte", 32'(out_byte), 32'(m_q[0]));
        chk(out_last === (m_rem == 1), "R5 out_last", 32'(out_last), 32'(m_rem == 1));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic configure(int code, longint bits);
    cfg_we = 1; cfg_order = 2'(code); cfg_len_bits = LEN_W'(bits);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send_word(logic [31:0] d);
    wr_valid = 1; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(wr_ready === 1'b1 && out_valid === 1'b0 && wr_err === 1'b0, "R1 reset",
        {29'd0, wr_ready, out_valid, wr_err}, 32'h4);
    // R7: write before configuration
    send_word(32'hDEADBEEF);
    idle(2);
    // R2 R3 R4 R5: order 0, 10 bytes over three words, word offered during guard
    configure(0, 80);
    send_word(32'h11223344);
    send_word(32'h55667788);
    send_word(32'h99AABBCC);
    idle(6);
    // R8: length exhausted
    send_word(32'h01020304);
    idle(2);
    // R9: backpressure, order 1
    bp_en = 1;
    configure(1, 64);
    send_word(32'hA1B2C3D4);
    send_word(32'hE5F60718);
    idle(12);
    // R2: low bits discarded, order 2, 3 bytes
    configure(2, 29);
    send_word(32'h0A0B0C0D);
    send_word(32'h12345678);
    idle(4);
    // R8: zero length, order 3
    configure(3, 0);
    send_word(32'hCAFEF00D);
    idle(2);
    configure(3, 40);
    send_word(32'h10203040);
    send_word(32'h50607080);
    idle(10);
    // R2: reconfigure while bytes are pending
    configure(0, 96);
    send_word(32'hFEDCBA98);
    configure(1, 32);
    send_word(32'h76543210);
    idle(10);
    bp_en = 0;
    idle(4);
    finish_run();
  end
endmodule